// File: doc/BRIEF.md
# Block-Lock Write Protection Controller

This block rules on every write that a serial bus front end hands over for a 16K-byte nonvolatile array and for a one-byte protection register at the top of the address space (FFFFh). The front end reports each received data byte together with its address and whether it is the first byte of the transaction. It also reports the end of the transaction, saying whether a stop or a new start closed it. The controller answers with an acknowledge decision for the byte. When the write closes, it either raises a pulse that launches a nonvolatile program cycle or a pulse that reports a volatile-only register change, or it does nothing.

The controller keeps two volatile enable latches: a write-enable latch and a register-update enable latch. It also keeps three persistent bits: two block-lock range bits and a hardware-lock enable. A change to the persistent bits needs a three-step sequence. Step one sets the write-enable latch, step two sets the register-update latch, and step three writes the new value. When the external lock pin is high and the hardware-lock enable is set, the persistent bits are frozen. The persistent bits are modelled as flops that clear only on the power-on reset. The soft reset clears only the volatile state.

Top module: `prot_ctrl`

## Requirements
- R1: Power-on reset clears all state. Soft reset clears only the two latches and keeps the range bits and the hardware-lock enable. The readback is bit 7 hardware-lock enable, bits 4:3 range bits, bit 2 update latch, bit 1 write latch, and zero in bits 6, 5 and 0.
- R2: While the write latch is 0, an array byte is not acknowledged and its stop launches no program cycle.
- R3: Writing 02h to FFFFh and closing with a stop sets the write latch and pulses `vol_done`.
- R4: Writing 06h to FFFFh sets the update latch only when the write latch is already 1. The change pulses `vol_done`.
- R5: While the update latch is 1, writing a byte of the form u00xy010 and closing with a stop loads u into the hardware-lock enable and xy into the range bits. It also clears the update latch and pulses `nv_start`.
- R6: A register byte with a one in bit 6, 5 or 0 changes nothing. So does a step-three byte that has bit 2 set; the update latch stays at 1.
- R7: Any write that is closed by a start instead of a stop changes no state and raises no pulse.
- R8: The range bits 00, 01, 10 and 11 protect no address, 3000h–3FFFh, 2000h–3FFFh and the whole array respectively. A byte into a protected range is still acknowledged, but its stop launches no program cycle.
- R9: With the pin and the hardware-lock enable both high, a step-three update is dropped. The latches and unprotected array addresses stay writable.
- R10: Only the first byte of a register write is acknowledged. Every byte of an enabled array write is acknowledged.
- R11: An array write to an unprotected address with the write latch set launches `nv_start` at its stop and clears the update latch.
- R12: Writing 00h clears the write latch only while the update latch is 0. While the update latch is 1, a 00h write changes nothing.
- R13: `ack_data` is high in the cycle after the byte strobe. `nv_start` and `vol_done` are high in the cycle after the end strobe. An end and a first byte in the same cycle close the old write and open the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| rst_n | input | 1 | Soft reset, active low, asynchronous; clears volatile state only |
| pp_pin | input | 1 | External hardware-lock pin |
| req_byte | input | 1 | Strobe: a data byte of a write has arrived |
| req_first | input | 1 | Qualifies `req_byte`: this is the first data byte |
| req_addr | input | ADDR_W | Target address of the byte |
| req_data | input | 8 | Data byte |
| req_end | input | 1 | Strobe: the current write has been closed |
| req_stop | input | 1 | Qualifies `req_end`: 1 = closed by stop, 0 = closed by start |
| ack_data | output | 1 | Acknowledge decision for the previous byte |
| nv_start | output | 1 | One-cycle pulse to launch a nonvolatile program cycle |
| vol_done | output | 1 | One-cycle pulse: volatile latch change completed |
| prot_rdback | output | 8 | Current protection register value |

## Verification
The end of one write can fall in the same cycle as the first byte of the next. The bench provokes this by closing an enabled array write and presenting a register byte in the same cycle. It then expects a program-cycle pulse and an acknowledge together, with the register op completing normally afterwards. A second collision comes from the lock pin: it is held high through a step-three stop while the hardware-lock enable is set, and the persistent bits must come out unchanged. The same update with the pin low must go through.

// File: rtl/prot_pkg.sv
package prot_pkg;
  typedef enum logic [1:0] {PK_NONE, PK_ARRAY, PK_LOCKED, PK_REG} pend_e;
  typedef enum logic [2:0] {OP_NONE, OP_SET_PEL, OP_CLR_PEL, OP_SET_RPEL, OP_NV_UPD} regop_e;

  localparam int BIT_LOCK = 7;
  localparam int BIT_RB1  = 4;
  localparam int BIT_RB0  = 3;
  localparam int BIT_UPD  = 2;
  localparam int BIT_WEN  = 1;
  localparam logic [7:0] RESV_MASK = 8'h61;
endpackage

// File: rtl/prot_lock_decode.sv
module prot_lock_decode #(
  parameter int ARRAY_AW = 14
) (
  input  logic [ARRAY_AW-1:0] addr,
  input  logic [1:0]          range_bits,
  output logic                locked
);
  localparam int TOP = ARRAY_AW - 1;
  logic [1:0] quarter;

  assign quarter = addr[TOP -: 2];

  always_comb begin
    unique case (range_bits)
      2'b00:   locked = 1'b0;
      2'b01:   locked = (quarter == 2'b11);
      2'b10:   locked = quarter[1];
      default: locked = 1'b1;
    endcase
  end
endmodule

// File: rtl/prot_cmd_decode.sv
module prot_cmd_decode
  import prot_pkg::*;
(
  input  logic [7:0] data,
  input  logic       wen,
  input  logic       upd,
  input  logic       hw_lock,
  output regop_e     op
);
  logic resv_clean;
  logic nv_fields;

  assign resv_clean = ((data & RESV_MASK) == 8'h00);
  assign nv_fields  = data[BIT_LOCK] | data[BIT_RB1] | data[BIT_RB0];

  always_comb begin
    op = OP_NONE;
    if (resv_clean) begin
      if (upd) begin
        if (!data[BIT_UPD] && data[BIT_WEN] && !hw_lock) op = OP_NV_UPD;
      end else if (!nv_fields) begin
        unique case ({data[BIT_UPD], data[BIT_WEN]})
          2'b01:   op = OP_SET_PEL;
          2'b11:   op = wen ? OP_SET_RPEL : OP_NONE;
          2'b00:   op = OP_CLR_PEL;
          default: op = OP_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/prot_ctrl.sv
module prot_ctrl
  import prot_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int ARRAY_AW = 14
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              pp_pin,
  input  logic              req_byte,
  input  logic              req_first,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic              req_end,
  input  logic              req_stop,
  output logic              ack_data,
  output logic              nv_start,
  output logic              vol_done,
  output logic [7:0]        prot_rdback
);
  localparam logic [ADDR_W-1:0] REG_ADDR = {ADDR_W{1'b1}};

  logic       vrst_n;
  pend_e      pend_q, pend_d;
  logic [7:0] data_q, data_d;
  logic       wen_q, wen_d, upd_q, upd_d;
  logic       ack_q, ack_d, nv_q, nv_d, done_q, done_d;
  logic       lock_q;
  logic [1:0] range_q;
  logic       nv_we;
  logic       is_reg, hw_lock, addr_locked;
  regop_e     op;

  assign vrst_n  = por_n & rst_n;
  assign is_reg  = (req_addr == REG_ADDR);
  assign hw_lock = pp_pin & lock_q;

  prot_lock_decode #(.ARRAY_AW(ARRAY_AW)) u_range (
    .addr       (req_addr[ARRAY_AW-1:0]),
    .range_bits (range_q),
    .locked     (addr_locked)
  );

  prot_cmd_decode u_cmd (
    .data    (data_q),
    .wen     (wen_q),
    .upd     (upd_q),
    .hw_lock (hw_lock),
    .op      (op)
  );

  assign nv_we = req_end & req_stop & (pend_q == PK_REG) & (op == OP_NV_UPD);

  always_comb begin
    pend_d = pend_q;
    data_d = data_q;
    wen_d  = wen_q;
    upd_d  = upd_q;
    ack_d  = 1'b0;
    nv_d   = 1'b0;
    done_d = 1'b0;
    if (req_end) begin
      pend_d = PK_NONE;
      if (req_stop) begin
        unique case (pend_q)
          PK_ARRAY: begin
            nv_d  = 1'b1;
            upd_d = 1'b0;
          end
          PK_REG: begin
            unique case (op)
              OP_SET_PEL:  begin wen_d = 1'b1; done_d = 1'b1; end
              OP_CLR_PEL:  begin wen_d = 1'b0; done_d = 1'b1; end
              OP_SET_RPEL: begin upd_d = 1'b1; done_d = 1'b1; end
              OP_NV_UPD:   begin upd_d = 1'b0; nv_d   = 1'b1; end
              default: ;
            endcase
          end
          default: ;
        endcase
      end
    end
    if (req_byte) begin
      if (req_first) begin
        if (is_reg) begin
          pend_d = PK_REG;
          data_d = req_data;
          ack_d  = 1'b1;
        end else if (wen_q) begin
          pend_d = addr_locked ? PK_LOCKED : PK_ARRAY;
          ack_d  = 1'b1;
        end else begin
          pend_d = PK_NONE;
        end
      end else begin
        ack_d = (pend_q == PK_ARRAY) || (pend_q == PK_LOCKED);
      end
    end
  end

  always_ff @(posedge clk or negedge vrst_n) begin
    if (!vrst_n) begin
      pend_q <= PK_NONE;
      data_q <= 8'h00;
      wen_q  <= 1'b0;
      upd_q  <= 1'b0;
      ack_q  <= 1'b0;
      nv_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      data_q <= data_d;
      wen_q  <= wen_d;
      upd_q  <= upd_d;
      ack_q  <= ack_d;
      nv_q   <= nv_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lock_q  <= 1'b0;
      range_q <= 2'b00;
    end else if (nv_we) begin
      lock_q  <= data_q[BIT_LOCK];
      range_q <= data_q[BIT_RB1:BIT_RB0];
    end
  end

  assign ack_data    = ack_q;
  assign nv_start    = nv_q;
  assign vol_done    = done_q;
  assign prot_rdback = {lock_q, 2'b00, range_q, upd_q, wen_q, 1'b0};
endmodule

// File: rtl/prot_ctrl_chk.sv
module prot_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_n,
  input logic              pp_pin,
  input logic              req_byte,
  input logic              req_first,
  input logic [ADDR_W-1:0] req_addr,
  input logic              ack_data,
  input logic              nv_start,
  input logic              vol_done,
  input logic [7:0]        prot_rdback
);
  // R13
  ack_after_byte_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    ack_data |-> $past(req_byte));

  // R5
  single_pulse_kind_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    !(nv_start && vol_done));

  // R11
  upd_cleared_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    nv_start |-> !prot_rdback[2]);

  // R9
  hw_freeze_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (pp_pin && prot_rdback[7]) |=> $stable(prot_rdback[7:3]));

  // R12
  wen_clear_order_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $fell(prot_rdback[1]) |-> !$past(prot_rdback[2]));

  // R2
  no_wen_no_ack_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (req_byte && req_first && (req_addr != {ADDR_W{1'b1}}) && !prot_rdback[1]) |=> !ack_data);
endmodule

bind prot_ctrl prot_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .rst_n       (rst_n),
  .pp_pin      (pp_pin),
  .req_byte    (req_byte),
  .req_first   (req_first),
  .req_addr    (req_addr),
  .ack_data    (ack_data),
  .nv_start    (nv_start),
  .vol_done    (vol_done),
  .prot_rdback (prot_rdback)
);

// File: tb/tb_prot_ctrl.sv
module tb_prot_ctrl;
  logic        clk = 1'b0;
  logic        por_n, rst_n, pp_pin;
  logic        req_byte, req_first, req_end, req_stop;
  logic [15:0] req_addr;
  logic [7:0]  req_data;
  logic        ack_data, nv_start, vol_done;
  logic [7:0]  prot_rdback;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  prot_ctrl dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .pp_pin(pp_pin),
    .req_byte(req_byte), .req_first(req_first), .req_addr(req_addr),
    .req_data(req_data), .req_end(req_end), .req_stop(req_stop),
    .ack_data(ack_data), .nv_start(nv_start), .vol_done(vol_done),
    .prot_rdback(prot_rdback)
  );

  typedef struct packed {
    logic [15:0] addr;
    logic [7:0]  data;
    logic        two;
    logic        stop;
    logic        pp;
    logic        ack0;
    logic        ack1;
    logic        nv;
    logic        done;
    logic [7:0]  rb;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t TBL [NV] = '{
    '{16'h0100, 8'h55, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'd2},  // R2
    '{16'hFFFF, 8'h06, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 4'd4},  // R4 no write latch
    '{16'hFFFF, 8'h02, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h02, 4'd3},  // R3
    '{16'hFFFF, 8'h06, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h02, 4'd7},  // R7
    '{16'hFFFF, 8'h06, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h06, 4'd10}, // R10 and R4
    '{16'hFFFF, 8'h0E, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h06, 4'd6},  // R6 bit2 set
    '{16'hFFFF, 8'h22, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h06, 4'd6},  // R6 reserved bit
    '{16'hFFFF, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h06, 4'd12}, // R12 blocked
    '{16'hFFFF, 8'h0A, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h06, 4'd7},  // R7 step three by start
    '{16'hFFFF, 8'h0A, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h0A, 4'd5},  // R5 range 01
    '{16'h3000, 8'h11, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0A, 4'd8},  // R8
    '{16'h2FFF, 8'h12, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h0A, 4'd11}, // R11
    '{16'hFFFF, 8'h06, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h0E, 4'd4},  // R4
    '{16'h0010, 8'h13, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h0A, 4'd11}, // R11 clears update latch
    '{16'hFFFF, 8'h06, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h0E, 4'd4},  // R4
    '{16'hFFFF, 8'h12, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h12, 4'd5},  // R5 range 10
    '{16'h2000, 8'h14, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h12, 4'd8},  // R8
    '{16'h1FFF, 8'h15, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h12, 4'd8},  // R8 edge below
    '{16'hFFFF, 8'h06, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h16, 4'd4},  // R4
    '{16'hFFFF, 8'h9A, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h9A, 4'd5},  // R5 range 11 + lock
    '{16'h0000, 8'h16, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h9A, 4'd8},  // R8 full array
    '{16'hFFFF, 8'h06, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h9E, 4'd9},  // R9 latch still settable
    '{16'hFFFF, 8'h02, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h9E, 4'd9},  // R9 update dropped
    '{16'hFFFF, 8'h02, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h02, 4'd5},  // R5 pin low
    '{16'hFFFF, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 4'd12}, // R12
    '{16'h0100, 8'h17, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4'd2},  // R2
    '{16'hFFFF, 8'h02, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h02, 4'd3},  // R3
    '{16'h0040, 8'h18, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h02, 4'd10}, // R10 array bytes
    '{16'hFFFF, 8'h06, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h06, 4'd4},  // R4
    '{16'hFFFF, 8'h8A, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h8A, 4'd5},  // R5
    '{16'h0000, 8'h19, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h8A, 4'd9},  // R9 unprotected array
    '{16'hFFFF, 8'h06, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h8E, 4'd9},  // R9
    '{16'hFFFF, 8'h02, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h8E, 4'd9}   // R9
  };

  task automatic chk(input string what, input int rq, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic send_byte(input logic [15:0] a, input logic [7:0] d, input logic first);
    req_byte = 1'b1; req_first = first; req_addr = a; req_data = d;
    @(posedge clk); @(negedge clk);
    req_byte = 1'b0; req_first = 1'b0;
  endtask

  task automatic close(input logic stop);
    req_end = 1'b1; req_stop = stop;
    @(posedge clk); @(negedge clk);
    req_end = 1'b0; req_stop = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    int rq;
    rq = int'(v.req);
    pp_pin = v.pp;
    send_byte(v.addr, v.data, 1'b1);
    chk("first ack", rq, {7'd0, ack_data}, {7'd0, v.ack0});
    if (v.two) begin
      send_byte(v.addr + 16'd1, v.data, 1'b0);
      chk("second ack", rq, {7'd0, ack_data}, {7'd0, v.ack1});
    end
    close(v.stop);
    chk("nv_start", rq, {7'd0, nv_start}, {7'd0, v.nv});
    chk("vol_done", rq, {7'd0, vol_done}, {7'd0, v.done});
    chk("readback", rq, prot_rdback, v.rb);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b0; pp_pin = 1'b0;
    req_byte = 1'b0; req_first = 1'b0; req_end = 1'b0; req_stop = 1'b0;
    req_addr = 16'h0000; req_data = 8'h00;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("reset readback", 1, prot_rdback, 8'h00);
    chk("reset pulses", 1, {5'd0, ack_data, nv_start, vol_done}, 8'h00);

    for (int i = 0; i < NV; i++) run_vec(TBL[i]);

    // R1 soft reset keeps persistent bits
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("soft reset readback", 1, prot_rdback, 8'h88);
    // R1 power-on reset clears them
    por_n = 1'b0; @(negedge clk); por_n = 1'b1; @(negedge clk);
    chk("por readback", 1, prot_rdback, 8'h00);

    // R13 end of one write with first byte of the next in the same cycle
    pp_pin = 1'b0;
    send_byte(16'hFFFF, 8'h02, 1'b1);
    close(1'b1);
    chk("wen set", 13, prot_rdback, 8'h02);
    send_byte(16'h0100, 8'h5A, 1'b1);
    chk("array ack", 13, {7'd0, ack_data}, 8'h01);
    req_end = 1'b1; req_stop = 1'b1;
    send_byte(16'hFFFF, 8'h00, 1'b1);
    req_end = 1'b0; req_stop = 1'b0;
    chk("overlap nv_start", 13, {7'd0, nv_start}, 8'h01);
    chk("overlap ack", 13, {7'd0, ack_data}, 8'h01);
    close(1'b1);
    chk("overlap reg done", 13, {7'd0, vol_done}, 8'h01);
    chk("overlap readback", 13, prot_rdback, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule